// File: doc/BRIEF.md
# Two-Source Interrupt Status and Mask Unit

This block collects two interrupt events and drives one interrupt line. The first event is a rising edge on a wait input. That input is assumed to be synchronised to `clk` already. The second event is a one-cycle pulse that signals that a strobe-extension limit has run out.

For each event the block keeps three bits:
- a raw status bit, which records every occurrence;
- a masked status bit, which records only the occurrences that arrive while the source is enabled;
- an enable bit.

Software reaches these bits through a small register port. The port has a write strobe, a 2-bit word offset and a combinational read-data path.

The port decodes four offsets:

| Offset | Register | Access |
|---|---|---|
| 0 | raw status | write 1 to clear |
| 1 | masked status | read only |
| 2 | enable set | write 1 to set; reads return the enable state |
| 3 | enable clear | write 1 to clear; reads return the enable state |

In every register, bit 0 belongs to the wait-rise source and bit 1 belongs to the timeout source. All other read bits are zero.

Top module: `evt_irq_status`

## Requirements
- R1: When `wait_in` is sampled high at a clock edge and was sampled low at the previous edge, raw bit 0 is set at that edge. Reset makes the block treat `wait_in` as previously high, so an input that is already high when reset ends produces no event until it has first been seen low.
- R2: A `tmo_in` pulse sampled at a clock edge sets raw bit 1 at that edge.
- R3: A raw bit is set whether or not its source is enabled. A masked bit is set only when the event occurs while the enable bit, as held before that edge, is 1.
- R4: Writing to offset 2 sets every enable bit whose data bit is 1. Writing to offset 3 clears every enable bit whose data bit is 1.
- R5: A read of offset 2 and a read of offset 3 both return the enable bits in bits [1:0], with zeros above them.
- R6: Writing a 1 to a bit at offset 0 clears that raw bit and the matching masked bit at the same edge.
- R7: `irq` is high exactly when at least one masked bit is set.
- R8: Data bits written as 0 change nothing in any register. A write to offset 1 changes nothing.
- R9: If an event and a clearing write reach the same bit at the same edge, the event wins and the raw bit stays set. The masked bit also stays set if the source is enabled.
- R10: Clearing an enable bit does not clear a masked bit that is already set.
- R11: After reset, all raw, masked and enable bits are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_in | input | 1 | Synchronised wait level; its rising edge is event 0 |
| tmo_in | input | 1 | One-cycle pulse: strobe-extension limit expired (event 1) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined interrupt output |

## Verification
A lost or stuck enable bit appears at `irq` on the next enabled event. It also appears at once in reads of offsets 2 and 3. A masked bit that fails to clear, or fails to set, shows on `irq` in the cycle after the faulty edge. For this reason `irq` and the addressed read data are compared with a behavioural model after every clock edge. The compared values include those for simultaneous clear-and-event edges and for writes of zero.

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_in,
  input  logic          tmo_in,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NSRC = 2;
  localparam logic [1:0] A_RAW = 2'd0, A_MSK = 2'd1, A_SET = 2'd2, A_CLR = 2'd3;

  logic            wait_q;
  logic [NSRC-1:0] raw_q, msk_q, en_q, evt, wbits;

  assign evt   = {tmo_in, wait_in & ~wait_q};
  assign wbits = bus_wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b1;
      raw_q  <= '0;
      msk_q  <= '0;
      en_q   <= '0;
    end else begin
      wait_q <= wait_in;
      if (bus_we && bus_addr == A_RAW) begin
        raw_q <= (raw_q & ~wbits) | evt;
        msk_q <= (msk_q & ~wbits) | (evt & en_q);
      end else begin
        raw_q <= raw_q | evt;
        msk_q <= msk_q | (evt & en_q);
      end
      if (bus_we && bus_addr == A_SET) en_q <= en_q | wbits;
      else if (bus_we && bus_addr == A_CLR) en_q <= en_q & ~wbits;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RAW:   bus_rdata[NSRC-1:0] = raw_q;
      A_MSK:   bus_rdata[NSRC-1:0] = msk_q;
      default: bus_rdata[NSRC-1:0] = en_q;
    endcase
  end

  assign irq = |msk_q;

  p_rise_sets_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_in && !wait_q) |=> raw_q[0]);
  p_tmo_sets_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_in |=> raw_q[1]);
  p_mask_needs_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q & ~raw_q) == '0);
  p_set_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET && bus_wdata[0]) |=> en_q[0]);
  p_clr_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR && bus_wdata[1]) |=> !en_q[1]);
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_RAW && bus_wdata[1] && !tmo_in) |=> (!raw_q[1] && !msk_q[1]));
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q) != '0);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_in && bus_we && bus_addr == A_RAW && bus_wdata[1]) |=> raw_q[1]);
endmodule

// File: tb/test_evt_irq_status.sv
module test_evt_irq_status;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_in = 1'b0, tmo_in = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  int m_raw = 0, m_msk = 0, m_en = 0;
  bit m_prev = 1'b1;

  always #2.5 clk = ~clk;

  evt_irq_status #(.DW(DW)) i_evt_irq_status (
    .clk(clk), .rst_n(rst_n), .wait_in(wait_in), .tmo_in(tmo_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic int exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_raw;
      2'd1: return m_msk;
      default: return m_en;
    endcase
  endfunction

  task automatic check(input string req);
    int er = exp_read(bus_addr);
    bit ei = (m_msk != 0);
    n_run++;
    if (bus_rdata !== DW'(er) || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: addr %0d rdata %0h irq %0b, expected rdata %0h irq %0b",
               req, bus_addr, bus_rdata, irq, er, ei);
    end
  endtask

  task automatic step(input bit w, input bit t, input bit we, input int a, input int d,
                      input string req);
    int ev, clr;
    @(negedge clk);
    wait_in = w; tmo_in = t; bus_we = we; bus_addr = 2'(a); bus_wdata = DW'(d);
    @(posedge clk);
    ev  = ((w && !m_prev) ? 1 : 0) | (t ? 2 : 0);
    m_prev = w;
    clr = (we && a == 0) ? (d & 3) : 0;
    m_raw = (m_raw & ~clr) | ev;
    m_msk = (m_msk & ~clr) | (ev & m_en);
    if (we && a == 2) m_en = m_en | (d & 3);
    if (we && a == 3) m_en = m_en & ~(d & 3);
    #1;
    check(req);
  endtask

  task automatic rd(input int a, input string req);
    step(wait_in, 1'b0, 1'b0, a, 0, req);
  endtask

  initial begin
    wait_in = 1'b1;
    #12; rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(a, "R11");
    rd(0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");
    rd(1, "R3");
    step(0, 1, 0, 0, 0, "R2");
    rd(1, "R3");
    step(0, 0, 1, 0, 0, "R8");
    step(0, 0, 1, 0, 1, "R6");
    step(0, 0, 1, 0, 2, "R6");
    step(0, 0, 1, 2, 1, "R4");
    rd(3, "R5");
    step(1, 0, 0, 1, 0, "R3");
    step(1, 0, 1, 1, 0, "R8");
    step(0, 0, 1, 1, 3, "R8");
    rd(0, "R3");
    step(0, 1, 0, 1, 0, "R3");
    step(0, 0, 1, 2, 2, "R4");
    rd(2, "R5");
    rd(3, "R5");
    step(0, 0, 1, 3, 0, "R8");
    step(0, 0, 1, 3, 1, "R10");
    rd(1, "R10");
    step(0, 0, 1, 0, 1, "R6");
    step(0, 0, 0, 1, 0, "R7");
    step(0, 1, 1, 0, 2, "R9");
    rd(1, "R9");
    step(1, 0, 1, 0, 1, "R9");
    step(0, 0, 1, 0, 3, "R6");
    step(0, 0, 0, 1, 0, "R7");
    step(0, 1, 1, 2, 1, "R3");
    rd(1, "R3");
    step(1, 0, 0, 1, 0, "R3");
    step(0, 0, 1, 3, 3, "R4");
    rd(2, "R5");
    step(1, 1, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 32'hFFFF_FFFF, "R6");
    for (int k = 0; k < 20; k++) step(k % 3 == 0, k % 5 == 0, k % 2 == 1, k % 4, k, "R7");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule